// File: doc/BRIEF.md
# UART Register Front End

This block sits between a processor bus and the shifting core of a UART. A single data address serves both directions. A write there loads a one-byte transmit holding buffer, and a read there takes the oldest byte out of a two-entry receive FIFO. Two more addresses carry a status byte and a control byte. The block hands the held byte to the transmit shift register when that register reports itself free. It accepts finished characters from the receive shifter and keeps the receive-available, transmit-complete, holding-buffer-empty and overrun flags.

Bus reads are registered. `rdata_o` carries the value one cycle after the edge that samples `rd_en_i`, and it is zero after an edge with no read. Address 0 is data, 1 is status and 2 is control. The control byte holds: bit 0 receiver enable, bit 1 transmitter enable, bits 3:2 character size (00 = 8 bits, 01 = 5, 10 = 6, 11 = 7), bit 4 receive interrupt enable, bit 5 transmit-complete interrupt enable, and bit 6 buffer-empty interrupt enable. The status byte holds: bit 7 receive data available, bit 6 transmit complete, bit 5 holding buffer empty, and bit 4 receive overrun. All other status bits read 0.

Top module: `uart_reg_front`

## Requirements
- R1: A write to address 0 while status bit 5 is 1 stores the byte in the holding buffer and clears status bit 5.
- R2: A write to address 0 while status bit 5 is 0 is dropped and leaves the held byte (`tx_data_o`) unchanged.
- R3: `tx_load_o` is 1, with the held byte on `tx_data_o`, in any cycle where the buffer is full, control bit 1 is set and `tx_ready_i` is 1. The edge that ends such a cycle empties the buffer.
- R4: The receive FIFO holds two bytes. Each read of address 0 returns the oldest byte and removes it, and a read of an empty FIFO returns 0. Reads of the status address remove nothing.
- R5: Received bytes have the bits above the selected character size forced to 0. Transmit bytes written to address 0 have the same bits forced to 0.
- R6: Status bit 7 is 1 exactly while the receive FIFO holds at least one byte.
- R7: While control bit 0 is 0, the receive FIFO is emptied and incoming characters are discarded, so status bit 7 reads 0.
- R8: Status bit 6 sets when `tx_done_i` pulses while the holding buffer is empty. It does not set if a byte is waiting.
- R9: Status bit 6 clears on a pulse of `irq_ack_i`, or on a status write with bit 6 = 1. A status write with bit 6 = 0 leaves it unchanged.
- R10: After reset the status byte reads 0x20, and the data and control reads return 0.
- R11: A character that arrives while the FIFO is full is dropped and sets status bit 4. Bit 4 stays set until the next read of address 0.
- R12: `rxc_irq_o`, `txc_irq_o` and `empty_irq_o` each equal their flag (status bit 7, 6 or 5) ANDed with their enable (control bit 4, 5 or 6), held as levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Registered bus read data |
| tx_ready_i | input | 1 | Transmit shift register is free |
| tx_done_i | input | 1 | Pulse: a frame has finished shifting out |
| tx_load_o | output | 1 | Holding byte is taken by the shift register this cycle |
| tx_data_o | output | 8 | Held transmit byte |
| rx_valid_i | input | 1 | Pulse: a received character is on rx_data_i |
| rx_data_i | input | 8 | Received character |
| irq_ack_i | input | 1 | Transmit-complete interrupt serviced |
| rxc_irq_o | output | 1 | Receive interrupt request level |
| txc_irq_o | output | 1 | Transmit-complete interrupt request level |
| empty_irq_o | output | 1 | Buffer-empty interrupt request level |

## Verification
The bench writes a second byte while the buffer is full and checks that the first byte is still the one handed over. A design that overwrote the buffer would send the second byte, and one that queued it would leave status bit 5 clear after the handover. A third character is pushed into a full FIFO, and the bench checks that it never appears and that the overrun bit clears only on a data read. A design that overwrote an entry would return the wrong order. Transmit-complete is tested with a byte still waiting and with a zero write to its bit, where a careless design sets or clears it. The receiver is disabled while it holds data, and a design that only gated new input would still report bytes after it is enabled again.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DATA = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CTRL = 2'd2
  } reg_addr_e;

  // status bit positions
  localparam int ST_RX    = 7;
  localparam int ST_TC    = 6;
  localparam int ST_EMPTY = 5;
  localparam int ST_OVR   = 4;

  typedef struct packed {
    logic       empty_ie;
    logic       txc_ie;
    logic       rxc_ie;
    logic [1:0] size;
    logic       tx_en;
    logic       rx_en;
  } ctrl_t;

  // size 0 -> full width, 1..3 -> DATA_W-3 .. DATA_W-1
  function automatic logic [DATA_W-1:0] char_mask(input logic [1:0] size,
                                                  input logic [DATA_W-1:0] d);
    int w;
    logic [DATA_W-1:0] r;
    w = (size == 2'd0) ? DATA_W : DATA_W - 4 + int'(size);
    for (int i = 0; i < DATA_W; i++) r[i] = (i < w) ? d[i] : 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_en_i,
  input  logic              tx_ready_i,
  input  logic              tx_done_i,
  input  logic              tc_clr_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              empty_o,
  output logic              tc_o
);
  logic              full_q;
  logic [DATA_W-1:0] hold_q;
  logic              tc_q;

  assign tx_load_o = full_q && tx_en_i && tx_ready_i;
  assign tx_data_o = hold_q;
  assign empty_o   = !full_q;
  assign tc_o      = tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      hold_q <= wdata_i;
    end else if (tx_load_o) begin
      full_q <= 1'b0;
    end
  end

  // a fresh completion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tc_q <= 1'b0;
    else if (tx_done_i && !full_q) tc_q <= 1'b1;
    else if (tc_clr_i)            tc_q <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_reg_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              avail_o,
  output logic              ovr_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovr_q;
  logic              do_pop, do_push, full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (!full || do_pop);
  assign head_o  = mem_q[rd_ptr_q];
  assign avail_o = (cnt_q != '0);
  assign ovr_o   = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (do_push && !flush_i) begin
      mem_q[wr_ptr_q] <= pdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovr_q <= 1'b0;
    else if (flush_i)            ovr_q <= 1'b0;
    else if (push_i && !do_push) ovr_q <= 1'b1;
    else if (pop_i)              ovr_q <= 1'b0;
  end
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rx_flag_i,
  input  logic              tc_flag_i,
  input  logic              empty_flag_i,
  output ctrl_t             ctrl_o,
  output logic              rxc_irq_o,
  output logic              txc_irq_o,
  output logic              empty_irq_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign ctrl_o      = ctrl_q;
  assign rxc_irq_o   = rx_flag_i    && ctrl_q.rxc_ie;
  assign txc_irq_o   = tc_flag_i    && ctrl_q.txc_ie;
  assign empty_irq_o = empty_flag_i && ctrl_q.empty_ie;
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_reg_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_ready_i,
  input  logic              tx_done_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              irq_ack_i,
  output logic              rxc_irq_o,
  output logic              txc_irq_o,
  output logic              empty_irq_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl;
  logic              wr_data, wr_stat, wr_ctrl, rd_data;
  logic              tx_empty, tc_flag, rx_avail, ovr, tc_clr;
  logic [DATA_W-1:0] rx_head, status, rdata_d, rdata_q;

  assign wr_data = wr_en_i && (addr_i == ADDR_DATA);
  assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign rd_data = rd_en_i && (addr_i == ADDR_DATA);
  assign tc_clr  = irq_ack_i || (wr_stat && wdata_i[ST_TC]);

  uart_tx_hold u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_data),
    .wdata_i    (char_mask(ctrl.size, wdata_i)),
    .tx_en_i    (ctrl.tx_en),
    .tx_ready_i (tx_ready_i),
    .tx_done_i  (tx_done_i),
    .tc_clr_i   (tc_clr),
    .tx_load_o  (tx_load_o),
    .tx_data_o  (tx_data_o),
    .empty_o    (tx_empty),
    .tc_o       (tc_flag)
  );

  uart_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!ctrl.rx_en),
    .push_i  (rx_valid_i && ctrl.rx_en),
    .pdata_i (char_mask(ctrl.size, rx_data_i)),
    .pop_i   (rd_data),
    .head_o  (rx_head),
    .avail_o (rx_avail),
    .ovr_o   (ovr)
  );

  uart_ctrl_regs u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_ctrl),
    .wdata_i      (wdata_i),
    .rx_flag_i    (rx_avail),
    .tc_flag_i    (tc_flag),
    .empty_flag_i (tx_empty),
    .ctrl_o       (ctrl),
    .rxc_irq_o    (rxc_irq_o),
    .txc_irq_o    (txc_irq_o),
    .empty_irq_o  (empty_irq_o)
  );

  always_comb begin
    status           = '0;
    status[ST_RX]    = rx_avail;
    status[ST_TC]    = tc_flag;
    status[ST_EMPTY] = tx_empty;
    status[ST_OVR]   = ovr;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_d = rx_avail ? rx_head : '0;
      ADDR_STAT: rdata_d = status;
      ADDR_CTRL: rdata_d = DATA_W'(ctrl);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en_i ? rdata_d : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk
  import uart_reg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_data,
  input logic              tx_empty,
  input logic              tx_load_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_done_i,
  input logic              irq_ack_i,
  input logic              tc_flag,
  input logic              rx_en,
  input logic              rx_avail,
  input logic              rx_valid_i,
  input logic              ovr
);
  assert_full_write_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !tx_empty) |=> $stable(tx_data_o));

  assert_load_frees_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> tx_empty);

  assert_rx_flag_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_avail) |-> $past(rx_valid_i && rx_en));

  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> !rx_avail);

  assert_tc_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_flag) |-> $past(tx_done_i && tx_empty));

  assert_tc_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !tx_done_i) |=> !tc_flag);

  assert_ovr_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr) |-> $past(rx_valid_i));
endmodule

bind uart_reg_front uart_reg_front_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_data    (wr_data),
  .tx_empty   (tx_empty),
  .tx_load_o  (tx_load_o),
  .tx_data_o  (tx_data_o),
  .tx_done_i  (tx_done_i),
  .irq_ack_i  (irq_ack_i),
  .tc_flag    (tc_flag),
  .rx_en      (ctrl.rx_en),
  .rx_avail   (rx_avail),
  .rx_valid_i (rx_valid_i),
  .ovr        (ovr)
);

// File: tb/uart_reg_front_test.sv
`timescale 1ns/1ps
module uart_reg_front_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_ready = 1'b0, tx_done = 1'b0;
  logic       tx_load;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       ack = 1'b0;
  logic       rxc_irq, txc_irq, empty_irq;

  int n_checks = 0, n_fail = 0;
  logic       finished = 1'b0;
  logic       rd_q = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2;

  always #2.5 clk = ~clk;

  uart_reg_front uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tx_ready_i(tx_ready), .tx_done_i(tx_done),
    .tx_load_o(tx_load), .tx_data_o(tx_data), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .irq_ack_i(ack), .rxc_irq_o(rxc_irq),
    .txc_irq_o(txc_irq), .empty_irq_o(empty_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each registered read result against the scoreboard
  always @(posedge clk) rd_q <= rd;
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 tx_load", {7'b0, tx_load}, 8'h00);
    check("R10 irqs", {5'b0, rxc_irq, txc_irq, empty_irq}, 8'h00);
    bus_read(A_STAT, 8'h20, "R10 status");
    bus_read(A_DATA, 8'h00, "R10 data");
    bus_read(A_CTRL, 8'h00, "R10 ctrl");

    // R1 R2 R3 load and handover
    bus_write(A_CTRL, 8'h03);
    bus_write(A_DATA, 8'hA5);
    bus_read(A_STAT, 8'h00, "R1 empty cleared");
    bus_write(A_DATA, 8'h3C);
    #1 check("R2 held byte kept", tx_data, 8'hA5);
    @(negedge clk); tx_ready = 1'b1;
    #1 check("R3 load asserted", {7'b0, tx_load}, 8'h01);
    check("R3 load data", tx_data, 8'hA5);
    @(negedge clk); tx_ready = 1'b0;
    #1 check("R3 load single cycle", {7'b0, tx_load}, 8'h00);
    bus_read(A_STAT, 8'h20, "R2 dropped byte not queued");

    // R3 transmitter disabled holds the byte
    bus_write(A_CTRL, 8'h01);
    bus_write(A_DATA, 8'h5A);
    @(negedge clk); tx_ready = 1'b1;
    #1 check("R3 no load while disabled", {7'b0, tx_load}, 8'h00);
    bus_read(A_STAT, 8'h00, "R3 still full");
    bus_write(A_CTRL, 8'h03);
    #1 check("R3 load after enable", {7'b0, tx_load}, 8'h01);
    @(negedge clk); tx_ready = 1'b0;
    bus_read(A_STAT, 8'h20, "R3 empty after load");

    // R8 R9 transmit complete
    pulse_done();
    bus_read(A_STAT, 8'h60, "R8 tc set");
    bus_write(A_STAT, 8'h00);
    bus_read(A_STAT, 8'h60, "R9 zero write no effect");
    bus_write(A_STAT, 8'h40);
    bus_read(A_STAT, 8'h20, "R9 write one clears");
    pulse_done();
    bus_read(A_STAT, 8'h60, "R8 tc set again");
    pulse_ack();
    bus_read(A_STAT, 8'h20, "R9 ack clears");
    bus_write(A_DATA, 8'h77);
    pulse_done();
    bus_read(A_STAT, 8'h00, "R8 no set while byte waiting");
    drain();
    bus_read(A_STAT, 8'h20, "R8 drained");

    // R12 interrupt levels
    bus_write(A_CTRL, 8'h63);
    #1 check("R12 empty irq", {7'b0, empty_irq}, 8'h01);
    check("R12 txc irq idle", {7'b0, txc_irq}, 8'h00);
    pulse_done();
    #1 check("R12 txc irq raised", {7'b0, txc_irq}, 8'h01);
    @(negedge clk);
    #1 check("R12 txc irq held", {7'b0, txc_irq}, 8'h01);
    pulse_ack();
    #1 check("R12 txc irq dropped", {7'b0, txc_irq}, 8'h00);
    bus_write(A_CTRL, 8'h73);
    #1 check("R12 rxc irq idle", {7'b0, rxc_irq}, 8'h00);

    // R4 R6 receive FIFO
    rx_push(8'h11);
    #1 check("R12 rxc irq raised", {7'b0, rxc_irq}, 8'h01);
    bus_read(A_STAT, 8'hA0, "R6 avail set");
    rx_push(8'h22);
    bus_read(A_DATA, 8'h11, "R4 first pop");
    bus_read(A_DATA, 8'h22, "R4 second pop");
    bus_read(A_STAT, 8'h20, "R6 avail clear");
    #1 check("R12 rxc irq dropped", {7'b0, rxc_irq}, 8'h00);
    rx_push(8'h42);
    bus_read(A_STAT, 8'hA0, "R4 status read no pop a");
    bus_read(A_STAT, 8'hA0, "R4 status read no pop b");
    bus_read(A_DATA, 8'h42, "R4 pop after status reads");

    // R11 overrun
    rx_push(8'h33);
    rx_push(8'h44);
    rx_push(8'h55);
    bus_read(A_STAT, 8'hB0, "R11 overrun set");
    bus_read(A_DATA, 8'h33, "R11 oldest kept");
    bus_read(A_STAT, 8'hA0, "R11 overrun cleared by read");
    bus_read(A_DATA, 8'h44, "R11 second kept");
    bus_read(A_DATA, 8'h00, "R4 empty read zero");

    // R5 character sizes
    bus_write(A_CTRL, 8'h77);
    rx_push(8'hFF);
    bus_read(A_DATA, 8'h1F, "R5 rx 5 bit");
    bus_write(A_CTRL, 8'h7B);
    rx_push(8'hFF);
    bus_read(A_DATA, 8'h3F, "R5 rx 6 bit");
    bus_write(A_CTRL, 8'h7F);
    rx_push(8'hFF);
    bus_read(A_DATA, 8'h7F, "R5 rx 7 bit");
    bus_write(A_CTRL, 8'h77);
    bus_write(A_DATA, 8'hFF);
    #1 check("R5 tx 5 bit", tx_data, 8'h1F);
    drain();

    // R7 flush on receiver disable
    bus_write(A_CTRL, 8'h73);
    rx_push(8'h66);
    rx_push(8'h99);
    bus_write(A_CTRL, 8'h72);
    bus_read(A_STAT, 8'h20, "R7 flushed");
    rx_push(8'hAB);
    bus_write(A_CTRL, 8'h73);
    bus_read(A_STAT, 8'h20, "R7 input ignored while off");
    bus_read(A_DATA, 8'h00, "R7 no stale data");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule